// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Registers

This block is the register file behind a message-signalled interrupt capability in PCI configuration space. Configuration reads and writes arrive as a byte offset, a size code (16 or 32 bits) and data. The block holds the control word, the message address (low and optional high half), the message data, and the optional per-vector mask and pending words. Two build-time straps decide whether the high address word exists and whether per-vector masking exists. Together they set where the data, mask and pending words sit and how long the structure is.

Downstream logic reads the programmed state straight from the outputs: the enable flag, the number of granted vectors, the 64-bit message address, the 16-bit data and one masked flag per vector. Three single-cycle pulses tell the interrupt router when to act. One marks enable going on, one marks enable going off, and one says that routing for every granted vector must be re-programmed. The block does not carry the bus transport and does not send messages.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset, enable is 0, the vector-grant field is 0, and the address, data and mask words are 0. Control bit 7 reads the 64-bit strap, bit 8 reads the masking strap, and bits 3:1 read the requested-vector parameter.
- R2: A control write changes only bit 0 (enable) and bits 6:4 (vector grant). It is either a 16-bit write at offset 0x2 or a 32-bit write at offset 0x0, which takes its control value from data bits 31:16. A 32-bit read at 0x0 returns the control word in bits 31:16.
- R3: The granted vector count is 1 shifted left by the grant field for field values 0 to 5, and 0 for values 6 and 7.
- R4: The low address word lives at offset 0x4, accepts only 32-bit writes and always stores bits 1:0 as zero.
- R5: With the 64-bit strap set, the high address word is at 0x8 and data is at 0xC. Without it, data is at 0x8 and the high address reads and drives 0.
- R6: With the masking strap set, the mask word follows the data word at the next 4-byte offset (0x10 or 0xC). Without the strap, a write there has no effect, it reads 0, and no vector is ever flagged masked.
- R7: Data accepts a 16-bit or a 32-bit write and keeps only the low 16 bits. The high address and mask words accept only 32-bit writes.
- R8: A write with size code 0 or 3, or to an offset that matches no register in the current layout, changes no register.
- R9: The structure length output is 10 bytes, plus 4 with the 64-bit strap, plus 10 with the masking strap.
- R10: In the cycle after a write that moves enable from 0 to 1, the rise pulse is 1 for one cycle. A write that moves it from 1 to 0 gives the fall pulse the same way.
- R11: In the cycle after any write, whether it matched a register or not, the refresh pulse is 1 if enable is then 1.
- R12: The pending word sits 4 bytes after the mask word when masking is strapped. It is a registered copy of the per-vector pending input and ignores writes. Every unimplemented offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one cycle |
| acc_off | input | 8 | Byte offset of the access |
| acc_sz | input | 2 | Size code: 1 = 16-bit, 2 = 32-bit, 0 and 3 invalid |
| wr_data | input | 32 | Write data, 16-bit writes in bits 15:0 |
| pend_in | input | NVEC | Per-vector pending state from the interrupt source |
| rd_data | output | 32 | Combinational read data for acc_off |
| msi_en | output | 1 | Enable flag |
| vec_count | output | 6 | Number of granted vectors |
| msg_addr | output | 64 | Programmed message address |
| msg_data | output | 16 | Programmed message data |
| vec_masked | output | NVEC | Per-vector masked flag |
| cap_len | output | 5 | Structure length in bytes |
| en_rise | output | 1 | Enable went on |
| en_fall | output | 1 | Enable went off |
| refresh | output | 1 | Re-program routing for all granted vectors |

## Verification
Two copies run on the same bus at once, one with both straps set and one with neither. Every offset therefore means different registers in the two layouts, and a decode that ignores a strap shows up as a mismatch at 0x8, 0xC or 0x10. Directed writes cover the control corners: all-ones upper half at 0x0, grant codes 5 to 7, and enable toggles with rising and falling pulses. Random offsets, sizes and data, including invalid size codes and odd offsets, separate correct write protection from writes that leak into neighbouring or read-only fields.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam int unsigned OFF_W = 8;
  localparam int unsigned CNT_W = 6;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_16   = 2'd1,
    SZ_32   = 2'd2,
    SZ_RSV  = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTL_UP,
    RD_CTL_LO,
    RD_ADDR_LO,
    RD_ADDR_HI,
    RD_DATA,
    RD_MASK,
    RD_PEND
  } rd_sel_e;

  typedef struct packed {
    logic ctl_lo;
    logic ctl_up;
    logic addr_lo;
    logic addr_hi;
    logic data;
    logic mask;
  } wr_sel_t;

  localparam logic [OFF_W-1:0] OFF_CTL_WORD = 8'h00;
  localparam logic [OFF_W-1:0] OFF_CTL      = 8'h02;
  localparam logic [OFF_W-1:0] OFF_ADDR_LO  = 8'h04;
  localparam logic [OFF_W-1:0] OFF_ADDR_HI  = 8'h08;

  // grant field to vector count; codes above 5 grant nothing
  function automatic logic [CNT_W-1:0] vec_count_f(input logic [2:0] grant);
    if (grant > 3'd5) return '0;
    return CNT_W'(1) << grant;
  endfunction

endpackage

// File: rtl/msi_cap_decode.sv
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter bit CAP_64  = 1'b1,
  parameter bit CAP_PVM = 1'b1
) (
  input  logic             wr_en,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       sz,
  output wr_sel_t          wsel,
  output rd_sel_e          rsel,
  output logic [4:0]       cap_len
);

  localparam logic [OFF_W-1:0] DATA_OFF = CAP_64 ? 8'h0C : 8'h08;
  localparam logic [OFF_W-1:0] MASK_OFF = DATA_OFF + 8'h04;
  localparam logic [OFF_W-1:0] PEND_OFF = MASK_OFF + 8'h04;
  localparam int unsigned      LEN      = 10 + (CAP_64 ? 4 : 0) + (CAP_PVM ? 10 : 0);

  assign cap_len = 5'(LEN);

  always_comb begin
    wsel = '0;
    if (wr_en) begin
      if (sz == SZ_16) begin
        wsel.ctl_lo = (off == OFF_CTL);
        wsel.data   = (off == DATA_OFF);
      end else if (sz == SZ_32) begin
        wsel.ctl_up  = (off == OFF_CTL_WORD);
        wsel.addr_lo = (off == OFF_ADDR_LO);
        wsel.data    = (off == DATA_OFF);
        wsel.addr_hi = CAP_64 && (off == OFF_ADDR_HI);
        wsel.mask    = CAP_PVM && (off == MASK_OFF);
      end
    end
  end

  always_comb begin
    if (off == OFF_CTL_WORD)                  rsel = RD_CTL_UP;
    else if (off == OFF_CTL)                  rsel = RD_CTL_LO;
    else if (off == OFF_ADDR_LO)              rsel = RD_ADDR_LO;
    else if (CAP_64 && off == OFF_ADDR_HI)    rsel = RD_ADDR_HI;
    else if (off == DATA_OFF)                 rsel = RD_DATA;
    else if (CAP_PVM && off == MASK_OFF)      rsel = RD_MASK;
    else if (CAP_PVM && off == PEND_OFF)      rsel = RD_PEND;
    else                                      rsel = RD_NONE;
  end

endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
#(
  parameter bit         CAP_64  = 1'b1,
  parameter bit         CAP_PVM = 1'b1,
  parameter logic [2:0] REQ_VEC = 3'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             ctl_we,
  input  logic [3:0]       ctl_field,   // {grant[2:0], enable}
  output logic [15:0]      ctl,
  output logic             en,
  output logic [CNT_W-1:0] vec_count,
  output logic             en_rise,
  output logic             en_fall,
  output logic             refresh
);

  logic       en_q, en_d;
  logic [2:0] grant_q, grant_d;
  logic       rise_d, fall_d, ref_d;
  logic       rise_q, fall_q, ref_q;

  always_comb begin
    en_d    = en_q;
    grant_d = grant_q;
    if (ctl_we) begin
      en_d    = ctl_field[0];
      grant_d = ctl_field[3:1];
    end
    rise_d = wr_en &  en_d & ~en_q;
    fall_d = wr_en & ~en_d &  en_q;
    ref_d  = wr_en &  en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      grant_q <= '0;
    end else if (ctl_we) begin
      en_q    <= en_d;
      grant_q <= grant_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
      ref_q  <= ref_d;
    end
  end

  assign ctl       = {7'b0, CAP_PVM, CAP_64, grant_q, REQ_VEC, en_q};
  assign en        = en_q;
  assign vec_count = vec_count_f(grant_q);
  assign en_rise   = rise_q;
  assign en_fall   = fall_q;
  assign refresh   = ref_q;

  a_r10_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |-> (en && !$past(en)));
  a_r10_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |-> (!en && $past(en)));
  a_r11_refresh_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |-> en);
  a_r3_count_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vec_count) <= 1);

endmodule

// File: rtl/msi_cap_store.sv
module msi_cap_store
  import msi_cap_pkg::*;
#(
  parameter bit          CAP_64  = 1'b1,
  parameter bit          CAP_PVM = 1'b1,
  parameter int unsigned NVEC    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      sz,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic            data_we,
  input  logic            mask_we,
  input  logic [31:0]     wr_data,
  input  logic [NVEC-1:0] pend_in,
  output logic [31:0]     addr_lo,
  output logic [31:0]     addr_hi,
  output logic [15:0]     data,
  output logic [31:0]     mask,
  output logic [31:0]     pend,
  output logic [NVEC-1:0] vec_masked
);

  logic [31:0] lo_q, lo_d;
  logic [15:0] data_q, data_d;

  always_comb begin
    lo_d   = lo_q;
    data_d = data_q;
    if (lo_we)   lo_d   = {wr_data[31:2], 2'b00};
    if (data_we) data_d = wr_data[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      data_q <= '0;
    end else begin
      if (lo_we)   lo_q   <= lo_d;
      if (data_we) data_q <= data_d;
    end
  end

  assign addr_lo = lo_q;
  assign data    = data_q;

  generate
    if (CAP_64) begin : g_hi
      logic [31:0] hi_q, hi_d;
      always_comb begin
        hi_d = hi_q;
        if (hi_we) hi_d = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_q <= '0;
        else if (hi_we) hi_q <= hi_d;
      end
      assign addr_hi = hi_q;
    end else begin : g_no_hi
      logic unused_hi;
      assign unused_hi = hi_we;
      assign addr_hi   = '0;
    end

    if (CAP_PVM) begin : g_pvm
      logic [31:0] mask_q, mask_d;
      always_comb begin
        mask_d = mask_q;
        if (mask_we) mask_d = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_d;
      end
      assign mask = mask_q;

      for (genvar i = 0; i < 32; i++) begin : g_bit
        if (i < NVEC) begin : g_live
          logic pend_q;
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= pend_in[i];
          end
          assign pend[i]       = pend_q;
          assign vec_masked[i] = mask_q[i];
        end else begin : g_pad
          assign pend[i] = 1'b0;
        end
      end

      a_r7_mask_32only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sz != SZ_32) |=> $stable(mask_q));
    end else begin : g_no_pvm
      logic unused_pvm;
      assign unused_pvm = ^{mask_we, pend_in, sz};
      assign mask       = '0;
      assign pend       = '0;
      assign vec_masked = '0;
    end
  endgenerate

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(lo_q) && $stable(data_q)));

endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter bit          CAP_64  = 1'b1,
  parameter bit          CAP_PVM = 1'b1,
  parameter logic [2:0]  REQ_VEC = 3'd5,
  parameter int unsigned NVEC    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       acc_off,
  input  logic [1:0]       acc_sz,
  input  logic [31:0]      wr_data,
  input  logic [NVEC-1:0]  pend_in,
  output logic [31:0]      rd_data,
  output logic             msi_en,
  output logic [5:0]       vec_count,
  output logic [63:0]      msg_addr,
  output logic [15:0]      msg_data,
  output logic [NVEC-1:0]  vec_masked,
  output logic [4:0]       cap_len,
  output logic             en_rise,
  output logic             en_fall,
  output logic             refresh
);

  // reset: asserted at once, released on the second clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  wr_sel_t     wsel;
  rd_sel_e     rsel;
  logic [3:0]  ctl_field;
  logic [15:0] ctl;
  logic [31:0] addr_lo, addr_hi, mask, pend;
  logic [15:0] data;

  msi_cap_decode #(.CAP_64(CAP_64), .CAP_PVM(CAP_PVM)) u_dec (
    .wr_en   (wr_en),
    .off     (acc_off),
    .sz      (acc_sz),
    .wsel    (wsel),
    .rsel    (rsel),
    .cap_len (cap_len)
  );

  assign ctl_field = wsel.ctl_up ? {wr_data[22:20], wr_data[16]}
                                 : {wr_data[6:4],   wr_data[0]};

  msi_cap_ctrl #(.CAP_64(CAP_64), .CAP_PVM(CAP_PVM), .REQ_VEC(REQ_VEC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (wr_en),
    .ctl_we    (wsel.ctl_lo | wsel.ctl_up),
    .ctl_field (ctl_field),
    .ctl       (ctl),
    .en        (msi_en),
    .vec_count (vec_count),
    .en_rise   (en_rise),
    .en_fall   (en_fall),
    .refresh   (refresh)
  );

  msi_cap_store #(.CAP_64(CAP_64), .CAP_PVM(CAP_PVM), .NVEC(NVEC)) u_store (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_en      (wr_en),
    .sz         (acc_sz),
    .lo_we      (wsel.addr_lo),
    .hi_we      (wsel.addr_hi),
    .data_we    (wsel.data),
    .mask_we    (wsel.mask),
    .wr_data    (wr_data),
    .pend_in    (pend_in),
    .addr_lo    (addr_lo),
    .addr_hi    (addr_hi),
    .data       (data),
    .mask       (mask),
    .pend       (pend),
    .vec_masked (vec_masked)
  );

  assign msg_addr = {addr_hi, addr_lo};
  assign msg_data = data;

  always_comb begin
    unique case (rsel)
      RD_CTL_UP:  rd_data = {ctl, 16'h0000};
      RD_CTL_LO:  rd_data = {16'h0000, ctl};
      RD_ADDR_LO: rd_data = addr_lo;
      RD_ADDR_HI: rd_data = addr_hi;
      RD_DATA:    rd_data = {16'h0000, data};
      RD_MASK:    rd_data = mask;
      RD_PEND:    rd_data = pend;
      default:    rd_data = '0;
    endcase
  end

  a_r4_lo_aligned: assert property (@(posedge clk) disable iff (!rst_n_s)
    msg_addr[1:0] == 2'b00);
  a_r6_mask_needs_strap: assert property (@(posedge clk) disable iff (!rst_n_s)
    (vec_masked != '0) |-> (ctl[8] && rsel != RD_NONE || ctl[8]));

endmodule

// File: tb/msi_cap_regs_test.sv
`timescale 1ns/1ps
module msi_cap_regs_test;

  localparam int NVEC = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  acc_off = '0;
  logic [1:0]  acc_sz = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] pend_in = '0;

  logic [31:0] o_rd   [2];
  logic [1:0]  o_en;
  logic [5:0]  o_cnt  [2];
  logic [63:0] o_addr [2];
  logic [15:0] o_data [2];
  logic [31:0] o_msk  [2];
  logic [4:0]  o_len  [2];
  logic [1:0]  o_rise, o_fall, o_ref;

  always #10 clk = ~clk;

  // layout A: both straps, 32 requested; layout B: no straps, 4 requested
  msi_cap_regs #(.CAP_64(1'b1), .CAP_PVM(1'b1), .REQ_VEC(3'd5), .NVEC(NVEC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_off(acc_off), .acc_sz(acc_sz),
    .wr_data(wr_data), .pend_in(pend_in), .rd_data(o_rd[0]), .msi_en(o_en[0]),
    .vec_count(o_cnt[0]), .msg_addr(o_addr[0]), .msg_data(o_data[0]),
    .vec_masked(o_msk[0]), .cap_len(o_len[0]), .en_rise(o_rise[0]),
    .en_fall(o_fall[0]), .refresh(o_ref[0]));

  msi_cap_regs #(.CAP_64(1'b0), .CAP_PVM(1'b0), .REQ_VEC(3'd2), .NVEC(NVEC)) uut_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .acc_off(acc_off), .acc_sz(acc_sz),
    .wr_data(wr_data), .pend_in(pend_in), .rd_data(o_rd[1]), .msi_en(o_en[1]),
    .vec_count(o_cnt[1]), .msg_addr(o_addr[1]), .msg_data(o_data[1]),
    .vec_masked(o_msk[1]), .cap_len(o_len[1]), .en_rise(o_rise[1]),
    .en_fall(o_fall[1]), .refresh(o_ref[1]));

  // bench model
  bit          cfg64  [2] = '{1'b1, 1'b0};
  bit          cfgpvm [2] = '{1'b1, 1'b0};
  logic [2:0]  cfgreq [2] = '{3'd5, 3'd2};
  logic        m_en   [2];
  logic [2:0]  m_gr   [2];
  logic [31:0] m_lo   [2];
  logic [31:0] m_hi   [2];
  logic [15:0] m_data [2];
  logic [31:0] m_mask [2];
  logic        m_rise [2];
  logic        m_fall [2];
  logic        m_ref  [2];
  logic [31:0] m_pend;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_cnt(input logic [2:0] g);
    return (g > 3'd5) ? 6'd0 : (6'd1 << g);
  endfunction

  function automatic logic [15:0] exp_ctl(input int c);
    return {7'b0, cfgpvm[c], cfg64[c], m_gr[c], cfgreq[c], m_en[c]};
  endfunction

  function automatic logic [31:0] exp_rd(input int c, input logic [7:0] off);
    logic [7:0] doff, moff;
    doff = cfg64[c] ? 8'h0C : 8'h08;
    moff = doff + 8'h04;
    if (off == 8'h00) return {exp_ctl(c), 16'h0};
    if (off == 8'h02) return {16'h0, exp_ctl(c)};
    if (off == 8'h04) return m_lo[c];
    if (cfg64[c] && off == 8'h08) return m_hi[c];
    if (off == doff) return {16'h0, m_data[c]};
    if (cfgpvm[c] && off == moff) return m_mask[c];
    if (cfgpvm[c] && off == moff + 8'h04) return m_pend;
    return 32'h0;
  endfunction

  task automatic model_write(input int c, input logic [7:0] off, input logic [1:0] sz,
                             input logic [31:0] d);
    logic [7:0] doff, moff;
    logic old;
    doff = cfg64[c] ? 8'h0C : 8'h08;
    moff = doff + 8'h04;
    old  = m_en[c];
    if (sz == 2'd1) begin
      if (off == 8'h02) begin m_en[c] = d[0]; m_gr[c] = d[6:4]; end
      else if (off == doff) m_data[c] = d[15:0];
    end else if (sz == 2'd2) begin
      if (off == 8'h00) begin m_en[c] = d[16]; m_gr[c] = d[22:20]; end
      else if (off == 8'h04) m_lo[c] = {d[31:2], 2'b00};
      else if (off == doff) m_data[c] = d[15:0];
      else if (cfg64[c] && off == 8'h08) m_hi[c] = d;
      else if (cfgpvm[c] && off == moff) m_mask[c] = d;
    end
    m_rise[c] = !old && m_en[c];
    m_fall[c] = old && !m_en[c];
    m_ref[c]  = m_en[c];
  endtask

  task automatic check_state(input int c);
    chk("R2", $sformatf("cfg%0d enable", c), 64'(o_en[c]), 64'(m_en[c]));
    chk("R3", $sformatf("cfg%0d vec_count", c), 64'(o_cnt[c]), 64'(exp_cnt(m_gr[c])));
    chk("R4", $sformatf("cfg%0d msg_addr", c), o_addr[c],
        {cfg64[c] ? m_hi[c] : 32'h0, m_lo[c]});
    chk("R7", $sformatf("cfg%0d msg_data", c), 64'(o_data[c]), 64'(m_data[c]));
    chk("R6", $sformatf("cfg%0d vec_masked", c), 64'(o_msk[c]),
        64'(cfgpvm[c] ? m_mask[c] : 32'h0));
    chk("R10", $sformatf("cfg%0d en_rise", c), 64'(o_rise[c]), 64'(m_rise[c]));
    chk("R10", $sformatf("cfg%0d en_fall", c), 64'(o_fall[c]), 64'(m_fall[c]));
    chk("R11", $sformatf("cfg%0d refresh", c), 64'(o_ref[c]), 64'(m_ref[c]));
  endtask

  task automatic do_wr(input logic [7:0] off, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; acc_off = off; acc_sz = sz; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    for (int c = 0; c < 2; c++) model_write(c, off, sz, d);
    for (int c = 0; c < 2; c++) check_state(c);
    for (int c = 0; c < 2; c++) begin m_rise[c] = 1'b0; m_fall[c] = 1'b0; m_ref[c] = 1'b0; end
  endtask

  task automatic do_rd(input string req, input logic [7:0] off);
    @(negedge clk);
    acc_off = off; acc_sz = 2'd2;
    #1;
    for (int c = 0; c < 2; c++)
      chk(req, $sformatf("cfg%0d read off %h", c, off), 64'(o_rd[c]), 64'(exp_rd(c, off)));
  endtask

  task automatic set_pend(input logic [31:0] v);
    @(negedge clk);
    pend_in = v;
    m_pend  = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] offs [9];
    void'($urandom(32'h5EED_0C4A));
    offs = '{8'h00, 8'h02, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18};
    for (int c = 0; c < 2; c++) begin
      m_en[c] = 0; m_gr[c] = 0; m_lo[c] = 0; m_hi[c] = 0; m_data[c] = 0; m_mask[c] = 0;
      m_rise[c] = 0; m_fall[c] = 0; m_ref[c] = 0;
    end
    m_pend = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int c = 0; c < 2; c++) check_state(c);
    do_rd("R1", 8'h02);
    do_rd("R1", 8'h04);
    do_rd("R1", 8'h0C);

    // R9 structure length
    chk("R9", "cfgA length", 64'(o_len[0]), 64'd24);
    chk("R9", "cfgB length", 64'(o_len[1]), 64'd10);

    // R2 upper-half control write with all ones: only enable and grant move
    do_wr(8'h00, 2'd2, 32'hFFFF_FFFF);
    do_rd("R2", 8'h00);
    do_rd("R2", 8'h02);
    // R3 grant codes 5 and 6; R10 fall on a 16-bit write
    do_wr(8'h02, 2'd1, 32'h0000_0050);
    do_wr(8'h02, 2'd1, 32'h0000_0061);
    do_wr(8'h02, 2'd1, 32'h0000_FF31);
    // R4 low address drops bits 1:0
    do_wr(8'h04, 2'd2, 32'hFFFF_FFFF);
    do_wr(8'h04, 2'd1, 32'h0000_1234);
    // R5 offset 0x8 means high address in A, data in B
    do_wr(8'h08, 2'd2, 32'hDEAD_BEEF);
    do_rd("R5", 8'h08);
    // R7 32-bit data write keeps low half; 16-bit mask write ignored
    do_wr(8'h0C, 2'd2, 32'hABCD_1234);
    do_wr(8'h10, 2'd1, 32'h0000_FFFF);
    // R6 mask write at 0x10 (A) and 0xC (B: absent)
    do_wr(8'h10, 2'd2, 32'h8000_0005);
    do_rd("R6", 8'h10);
    // R8 invalid sizes and unmatched offset
    do_wr(8'h04, 2'd0, 32'h5555_5555);
    do_wr(8'h0C, 2'd3, 32'h5555_5555);
    do_wr(8'h06, 2'd2, 32'h5555_5555);
    do_rd("R8", 8'h04);
    // R12 pending mirror, write ignored, unimplemented reads
    set_pend(32'hA5A5_0F0F);
    do_wr(8'h14, 2'd2, 32'h0000_0000);
    do_rd("R12", 8'h14);
    do_rd("R12", 8'h18);
    do_rd("R12", 8'h40);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] off;
      int pick;
      pick = $urandom_range(0, 9);
      off  = (pick == 9) ? 8'($urandom) : offs[pick];
      if ($urandom_range(0, 3) == 0) set_pend($urandom);
      do_wr(off, 2'($urandom_range(0, 3)), $urandom);
      do_rd("R12", offs[$urandom_range(0, 8)]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule